// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a free-running system clock into the quantized bit clock of a CAN receiver. A prescaler derives the time quantum. Each nominal bit then runs through four parts in turn: a one-quantum synchronization slot, a propagation part, a first phase part and a second phase part. The bus level is captured at the end of the first phase part. That capture is the sample point, and it is announced by a one-cycle strobe together with the captured bit. A second strobe marks the end of every synchronization slot, so that framing logic downstream can count bits.

The bus input passes through a two-flop synchronizer, and the synchronized level is then checked once per quantum for recessive-to-dominant transitions. While the bus is idle, such a transition restarts the bit at once (hard synchronization). Inside a frame, a transition that arrives after its expected slot stretches the first phase part. A transition that arrives in the second phase part cuts that part short. Either correction is limited to the jump width, and at most one is applied between two sample points. No correction is made while the node itself is driving dominant. The bus counts as idle after eleven recessive samples in a row.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts `cfg_brp` clock cycles. With no falling edges on the bus, successive sample strobes are `cfg_brp*(1+cfg_prop+cfg_ph1+cfg_ph2)` cycles apart.
- R2: `bit_stb` pulses for one cycle at the end of the synchronization quantum. `sample_stb` pulses `cfg_prop+cfg_ph1` quanta later, and the two never pulse in the same cycle.
- R3: The bus input is re-timed through two flops. With `cfg_brp`=1, a change on `rx_async` set up before rising edge k is seen by the timer at rising edge k+2. `rx_bit` is the re-timed level captured with `sample_stb`, it changes only together with that strobe, and no strobe appears at any other time.
- R4: While `bus_idle` is high, a falling edge ends the synchronization quantum in the quantum where it is seen. `bit_stb` pulses in that cycle and `sample_stb` does not. The next sample follows `cfg_prop+cfg_ph1` quanta later.
- R5: A falling edge seen e quanta after the synchronization quantum (e not above `cfg_sjw`) lengthens the first phase part by e.
- R6: A late edge with e above `cfg_sjw` lengthens the first phase part by exactly `cfg_sjw`.
- R7: A falling edge seen in the second phase part, with d quanta remaining up to and including the next synchronization quantum (d not above `cfg_sjw`), ends the bit at once. The next quantum starts the propagation part.
- R8: An early edge with d above `cfg_sjw` removes exactly `cfg_sjw` quanta from the bit.
- R9: A falling edge seen in the synchronization quantum leaves the bit timing unchanged.
- R10: Only the first falling edge between two sample points adjusts timing. Rising edges never do.
- R11: While `tx_bit` is 0 (the node sends dominant), falling edges inside a frame cause no adjustment.
- R12: `bus_idle` is 0 after reset. It rises with the sample strobe of the eleventh consecutive recessive (1) sample, and it falls on a hard synchronization.
- R13: After reset, `sample_stb`, `bit_stb` and `bus_idle` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_async | input | 1 | Bus receive line, not synchronized; 0 is dominant |
| tx_bit | input | 1 | Level this node is currently transmitting |
| cfg_brp | input | PW | Clock cycles per quantum |
| cfg_prop | input | SW | Propagation part length in quanta |
| cfg_ph1 | input | SW | First phase part length in quanta |
| cfg_ph2 | input | SW | Second phase part length in quanta |
| cfg_sjw | input | SW | Largest correction per resynchronization, in quanta |
| rx_bit | output | 1 | Bus level taken at the last sample point |
| sample_stb | output | 1 | One-cycle pulse at each sample point |
| bit_stb | output | 1 | One-cycle pulse at the end of each synchronization quantum |
| bus_idle | output | 1 | Bus seen recessive for eleven bits in a row |

## Verification
The hardest cases to reach are the ones where a single edge falls in a chosen quantum of the local bit: one or two quanta late, four late, one early, three early, or a short glitch that produces two falling edges before one sample. The local phase depends on every earlier correction, so the stimulus is one continuous frame with the quantum set to one clock. After a hard synchronization whose timing is fully known, each later edge is placed at a computed offset from the boundary the timer is expected to hold after the previous correction. The expected sample cycles are then pushed into the scoreboard before the frame starts.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PW = 8,
  parameter int SW = 4,
  parameter int IDLE_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_async,
  input  logic          tx_bit,
  input  logic [PW-1:0] cfg_brp,
  input  logic [SW-1:0] cfg_prop,
  input  logic [SW-1:0] cfg_ph1,
  input  logic [SW-1:0] cfg_ph2,
  input  logic [SW-1:0] cfg_sjw,
  output logic          rx_bit,
  output logic          sample_stb,
  output logic          bit_stb,
  output logic          bus_idle
);
  localparam int TW = SW + 2;
  localparam int IW = $clog2(IDLE_BITS + 1);

  typedef enum logic [1:0] {SEG_SYNC, SEG_T1, SEG_PH2} seg_t;

  logic [1:0]    sync_q;
  logic [PW-1:0] pc;
  seg_t          seg;
  logic [TW-1:0] cnt, ext;
  logic          lvl, rs_done;
  logic [IW-1:0] rec_cnt;

  wire rx_s   = sync_q[1];
  wire tick   = ({1'b0, pc} + 1'b1) >= {1'b0, cfg_brp};
  wire fall   = tick & lvl & ~rx_s;
  wire hard   = fall & bus_idle;
  wire resync = fall & ~bus_idle & ~rs_done & tx_bit;
  wire late   = resync & (seg == SEG_T1);
  wire early  = resync & (seg == SEG_PH2);

  wire [TW-1:0] sjw    = TW'(cfg_sjw);
  wire [TW-1:0] ph2    = TW'(cfg_ph2);
  wire [TW-1:0] t1_len = TW'(cfg_prop) + TW'(cfg_ph1);
  wire [TW-1:0] late_e = cnt + TW'(1);
  wire [TW-1:0] ph2_e  = ph2 - cnt;
  wire [TW-1:0] ext_n  = late ? ((late_e < sjw) ? late_e : sjw) : ext;
  wire [TW-1:0] skip   = cnt + TW'(1) + sjw;

  wire t1_done    = (seg == SEG_T1) && (cnt == t1_len - TW'(1) + ext_n);
  wire ph2_last   = (seg == SEG_PH2) && (cnt == ph2 - TW'(1));
  wire early_full = early && (ph2_e <= sjw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      pc         <= '0;
      seg        <= SEG_SYNC;
      cnt        <= '0;
      ext        <= '0;
      lvl        <= 1'b1;
      rs_done    <= 1'b0;
      rec_cnt    <= '0;
      bus_idle   <= 1'b0;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], rx_async};
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
      pc         <= tick ? '0 : pc + 1'b1;
      if (tick) begin
        lvl <= rx_s;
        if (hard || resync) rs_done <= 1'b1;
        if (hard || early_full || seg == SEG_SYNC) begin
          seg     <= SEG_T1;
          cnt     <= '0;
          ext     <= '0;
          bit_stb <= 1'b1;
          if (hard) bus_idle <= 1'b0;
        end else if (seg == SEG_T1) begin
          ext <= ext_n;
          if (t1_done) begin
            seg        <= SEG_PH2;
            cnt        <= '0;
            sample_stb <= 1'b1;
            rx_bit     <= rx_s;
            rs_done    <= 1'b0;
            if (!rx_s) rec_cnt <= '0;
            else if (rec_cnt != IW'(IDLE_BITS)) rec_cnt <= rec_cnt + 1'b1;
            if (rx_s && rec_cnt >= IW'(IDLE_BITS - 1)) bus_idle <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (early) begin
          if (skip >= ph2) begin
            seg <= SEG_SYNC;
            cnt <= '0;
          end else begin
            cnt <= skip;
          end
        end else if (ph2_last) begin
          seg <= SEG_SYNC;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: sample point and bit boundary are distinct events
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, bit_stb}));

  // R3: captured bit only moves at a sample point
  a_r3_rx_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> sample_stb);

  // R1: a sample strobe is never followed directly by another
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R12: idle is declared only by a recessive sample
  a_r12_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> (sample_stb && rx_bit));

  // R4: idle ends only through a hard synchronization
  a_r4_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_idle) |-> bit_stb);
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_async = 1'b1;
  logic       tx_bit = 1'b1;
  logic [7:0] cfg_brp = 8'd1;
  logic [3:0] cfg_prop = 4'd2;
  logic [3:0] cfg_ph1 = 4'd3;
  logic [3:0] cfg_ph2 = 4'd3;
  logic [3:0] cfg_sjw = 4'd2;
  logic       rx_bit, sample_stb, bit_stb, bus_idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  int    exp_t[$];
  bit    exp_b[$];
  string exp_r[$];

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_async(rx_async), .tx_bit(tx_bit),
    .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1),
    .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_stb(bit_stb),
    .bus_idle(bus_idle)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
    end
  endtask

  task automatic at(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(int t, bit b, string r);
    exp_t.push_back(t);
    exp_b.push_back(b);
    exp_r.push_back(r);
  endtask

  always @(negedge clk) begin
    if (armed && sample_stb) begin
      checks++;
      if (exp_t.size() == 0) begin
        errors++;
        $display("FAIL R3 stray sample strobe at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        int    t;
        bit    b;
        string r;
        t = exp_t.pop_front();
        b = exp_b.pop_front();
        r = exp_r.pop_front();
        if (cyc != t || rx_bit != b) begin
          errors++;
          $display("FAIL %s sample: actual cycle %0d bit %0d expected cycle %0d bit %0d",
                   r, cyc, rx_bit, t, b);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    int t1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 sample_stb", sample_stb, 0);
    chk("R13 bit_stb", bit_stb, 0);
    chk("R13 bus_idle", bus_idle, 0);
    chk("R13 rx_bit", rx_bit, 1);
    rst_n = 1'b1;

    // R12 idle after eleven recessive samples
    cnt = 0;
    while (!bus_idle) begin
      @(negedge clk);
      if (sample_stb) cnt++;
    end
    chk("R12 samples before idle", cnt, 11);
    chk("R12 idle with strobe", sample_stb, 1);

    // frame with corrections; one quantum per clock, bit of 9 quanta
    repeat (5) @(negedge clk);
    n = cyc;
    push(n + 8,   0, "R4");
    push(n + 17,  1, "R1");
    push(n + 26,  0, "R9");
    push(n + 35,  1, "R1");
    push(n + 46,  0, "R5");
    push(n + 55,  1, "R5");
    push(n + 66,  0, "R6");
    push(n + 75,  1, "R6");
    push(n + 83,  0, "R7");
    push(n + 92,  1, "R7");
    push(n + 99,  0, "R8");
    push(n + 108, 1, "R8");
    push(n + 117, 0, "R11");
    push(n + 126, 1, "R11");
    push(n + 136, 0, "R10");
    for (int k = 0; k < 11; k++) push(n + 145 + 9 * k, 1, "R12");

    rx_async = 1'b0;
    at(n + 3);
    chk("R4 bit_stb on hard sync", bit_stb, 1);
    chk("R4 no sample on hard sync", sample_stb, 0);
    #1 armed = 1'b1;
    at(n + 8);  chk("R12 idle cleared by hard sync", bus_idle, 0);
    at(n + 9);  rx_async = 1'b1;
    at(n + 12); chk("R2 bit_stb at end of sync quantum", bit_stb, 1);
    at(n + 18); rx_async = 1'b0;
    at(n + 27); rx_async = 1'b1;
    at(n + 38); rx_async = 1'b0;
    at(n + 47); rx_async = 1'b1;
    at(n + 60); rx_async = 1'b0;
    at(n + 67); rx_async = 1'b1;
    at(n + 75); rx_async = 1'b0;
    at(n + 84); rx_async = 1'b1;
    at(n + 90); rx_async = 1'b0;
    at(n + 100); rx_async = 1'b1; tx_bit = 1'b0;
    at(n + 111); rx_async = 1'b0;
    at(n + 118); rx_async = 1'b1; tx_bit = 1'b1;
    at(n + 128); rx_async = 1'b0;
    at(n + 129); rx_async = 1'b1;
    at(n + 130); rx_async = 1'b0;
    at(n + 137); rx_async = 1'b1;
    at(n + 234); chk("R12 idle not yet after ten", bus_idle, 0);
    at(n + 235); chk("R12 idle after eleven", bus_idle, 1);
    at(n + 240);
    armed = 1'b0;
    chk("R3 all expected samples seen", exp_t.size(), 0);

    // R1 prescaler of three clocks per quantum
    cfg_brp = 8'd3;
    cnt = 0;
    t1 = 0;
    while (cnt < 3) begin
      @(negedge clk);
      if (sample_stb) begin
        cnt++;
        if (cnt == 2) t1 = cyc;
        if (cnt == 3) chk("R1 bit period with prescaler 3", cyc - t1, 27);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule